// File: doc/BRIEF.md
# Gate Program Rule Checker

This block validates a short program of logic-gate slots before the program is evaluated anywhere else. Each slot names a gate, up to two source operands and a destination. A source operand is either one of four input ports or one of ten scratch registers. A destination is either one of four output ports or one of ten scratch registers. The block reads the slots one at a time from an external memory with a combinational read. It scans them in ascending order and stops at the first slot that breaks a rule.

The block keeps a ten-bit record of the scratch registers that earlier slots have already written. From this record it enforces two rules. A register can be assigned only once. A register can be read only after an earlier slot has written it. A start pulse begins the scan. A one-cycle done pulse ends it. With the done pulse come a pass flag, the index of the offending slot and a code that says which rule failed. These results stay on the outputs until the next done pulse.

Top module: `gate_prog_checker`

## Requirements
- R1: A slot word has 22 bits. Bit 21 is the occupied flag, bits 20:18 the gate, bits 17:12 operand A, bits 11:6 operand B and bits 5:0 the destination. When every occupied slot is legal, done rises after 14 evaluation cycles with pass=1, fail_code=0 and fail_slot=0.
- R2: A slot whose bit 21 is 0 is skipped. Its other bits never cause an error and never mark a register as written, so a program with no occupied slots passes.
- R3: Gate codes are 1 AND, 2 OR, 3 NOT, 4 XOR, 5 NAND, 6 BUF and 7 XNOR. An occupied slot with gate code 0 fails with code 1.
- R4: Each 6-bit operand field holds a present bit [5], a kind bit [4] (1 for a register, 0 for a port) and an index [3:0]. NOT and BUF need operand A absent and both operand B and the destination present. Every other gate needs all three fields present. A slot that breaks this fails with code 2.
- R5: If both operands have the same kind and the same index, the slot fails with code 3. This applies to ports as well as registers.
- R6: If the destination register equals either operand register, the slot fails with code 4. An output port with the same index as an input-port operand is legal.
- R7: A register operand that no earlier slot has written fails with code 5 when it is operand A and code 6 when it is operand B.
- R8: A destination register that an earlier slot has already written fails with code 7.
- R9: Within one slot the codes take priority in ascending order (1 first). The scan stops at the first failing slot. That slot's zero-based index appears on fail_slot, with pass=0, and done rises index+1 cycles after the start edge.
- R10: done is high for exactly one cycle. pass, fail_slot and fail_code hold between done pulses. A start pulse during a scan is ignored. mem_addr steps by one from 0 on each cycle of the scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (ignored while scanning) |
| mem_addr | output | 4 | Slot index being read |
| mem_data | input | 22 | Slot word at mem_addr, same cycle |
| done | output | 1 | One-cycle end-of-scan pulse |
| pass | output | 1 | Program is valid |
| fail_slot | output | 4 | Index of the first failing slot |
| fail_code | output | 3 | Rule that failed, 0 when valid |

## Verification
The hardest case to reach from the ports is a late register fault, such as a reused destination or an undefined read in the last slot. To produce it, many earlier slots must be legal, and the written-register record must be full and accurate when the bad slot is read. The stimulus starts from a complete legal program that writes all ten registers. It then changes a single slot to inject each fault at a chosen position. It also generates random programs, mostly legal, that track which registers are written and sometimes corrupt one field. A behavioural model in the bench predicts the code, the slot and the done cycle for each program.

// File: rtl/gate_prog_checker.sv
module gate_prog_checker #(
  parameter int SLOTS = 14,
  parameter int REGS  = 10,
  parameter int IDXW  = 4,
  localparam int OPW   = IDXW + 2,
  localparam int WORDW = 4 + 3 * OPW,
  localparam int AW    = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [AW-1:0]    mem_addr,
  input  logic [WORDW-1:0] mem_data,
  output logic             done,
  output logic             pass,
  output logic [AW-1:0]    fail_slot,
  output logic [2:0]       fail_code
);
  localparam int XW = 2 ** IDXW;

  logic            busy;
  logic [REGS-1:0] written;
  logic [XW-1:0]   wr_ext;
  logic [XW-1:0]   dst_bit;
  logic [2:0]      code;

  wire             occupied = mem_data[WORDW-1];
  wire [2:0]       gate     = mem_data[WORDW-2 -: 3];
  wire [OPW-1:0]   opa      = mem_data[3*OPW-1 -: OPW];
  wire [OPW-1:0]   opb      = mem_data[2*OPW-1 -: OPW];
  wire [OPW-1:0]   dst      = mem_data[OPW-1:0];

  wire a_on  = opa[OPW-1];
  wire b_on  = opb[OPW-1];
  wire d_on  = dst[OPW-1];
  wire a_reg = opa[OPW-2];
  wire b_reg = opb[OPW-2];
  wire d_reg = dst[OPW-2];
  wire [IDXW-1:0] a_idx = opa[IDXW-1:0];
  wire [IDXW-1:0] b_idx = opb[IDXW-1:0];
  wire [IDXW-1:0] d_idx = dst[IDXW-1:0];

  assign wr_ext  = XW'(written);
  assign dst_bit = XW'(1) << d_idx;

  wire unary   = (gate == 3'd3) || (gate == 3'd6);
  wire missing = unary ? (a_on || !b_on || !d_on) : (!a_on || !b_on || !d_on);
  wire same_ab = a_on && (a_reg == b_reg) && (a_idx == b_idx);
  wire d_hits  = d_reg && ((a_on && a_reg && a_idx == d_idx) || (b_reg && b_idx == d_idx));
  wire a_undef = a_on && a_reg && !wr_ext[a_idx];
  wire b_undef = b_reg && !wr_ext[b_idx];
  wire d_reuse = d_reg && wr_ext[d_idx];

  always_comb begin
    if (gate == 3'd0)  code = 3'd1;
    else if (missing)  code = 3'd2;
    else if (same_ab)  code = 3'd3;
    else if (d_hits)   code = 3'd4;
    else if (a_undef)  code = 3'd5;
    else if (b_undef)  code = 3'd6;
    else if (d_reuse)  code = 3'd7;
    else               code = 3'd0;
  end

  wire bad  = occupied && (code != 3'd0);
  wire last = (mem_addr == AW'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mem_addr  <= '0;
      written   <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_slot <= '0;
      fail_code <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          mem_addr <= '0;
          written  <= '0;
        end
      end else if (bad) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        pass      <= 1'b0;
        fail_code <= code;
        fail_slot <= mem_addr;
      end else begin
        if (occupied && d_reg)
          written <= written | dst_bit[REGS-1:0];
        if (last) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          pass      <= 1'b1;
          fail_code <= '0;
          fail_slot <= '0;
        end else begin
          mem_addr <= mem_addr + 1'b1;
        end
      end
    end
  end
endmodule

module gate_prog_checker_sva #(
  parameter int SLOTS = 14,
  parameter int AW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          pass,
  input logic [AW-1:0] fail_slot,
  input logic [2:0]    fail_code
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (fail_code == 3'd0 && fail_slot == '0));
  a_r9_fail_coded: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> (fail_code != 3'd0 && fail_slot < AW'(SLOTS)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pass) && $stable(fail_code) && $stable(fail_slot)));
  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr == $past(mem_addr) + AW'(1)));
  a_r10_start_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mem_addr == '0));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind gate_prog_checker gate_prog_checker_sva #(.SLOTS(SLOTS), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_addr(mem_addr),
  .done(done), .pass(pass), .fail_slot(fail_slot), .fail_code(fail_code)
);

// File: tb/gate_prog_checker_tb.sv
module gate_prog_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mem_addr;
  logic [21:0] mem_data;
  logic        done, pass;
  logic [3:0]  fail_slot;
  logic [2:0]  fail_code;

  logic [21:0] prog [N];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign mem_data = (mem_addr < 4'(N)) ? prog[mem_addr] : 22'd0;

  gate_prog_checker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_data(mem_data), .done(done), .pass(pass),
    .fail_slot(fail_slot), .fail_code(fail_code)
  );

  function automatic logic [5:0] R(int i); return {2'b11, 4'(i)}; endfunction
  function automatic logic [5:0] P(int i); return {2'b10, 4'(i)}; endfunction
  localparam logic [5:0] NONE = 6'd0;
  function automatic logic [21:0] S(int g, logic [5:0] a, logic [5:0] b, logic [5:0] d);
    return {1'b1, 3'(g), a, b, d};
  endfunction

  function automatic string tag(int c);
    case (c)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(output int code, output int at);
    bit w[16];
    code = 0; at = 0;
    foreach (w[k]) w[k] = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic [21:0] s; logic [5:0] a, b, d; int g, c;
      s = prog[i];
      if (!s[21]) continue;
      g = int'(s[20:18]); a = s[17:12]; b = s[11:6]; d = s[5:0];
      c = 0;
      if (g == 0) c = 1;
      else if ((g == 3 || g == 6) ? (a[5] || !b[5] || !d[5]) : (!a[5] || !b[5] || !d[5])) c = 2;
      else if (a[5] && a[4:0] == b[4:0]) c = 3;
      else if (d[4] && ((a[5] && a[4:0] == d[4:0]) || b[4:0] == d[4:0])) c = 4;
      else if (a[5] && a[4] && !w[a[3:0]]) c = 5;
      else if (b[4] && !w[b[3:0]]) c = 6;
      else if (d[4] && w[d[3:0]]) c = 7;
      if (c != 0) begin code = c; at = i; return; end
      if (d[4]) w[d[3:0]] = 1'b1;
    end
  endtask

  task automatic run(input bit poke);
    int ec, es, lat;
    model(ec, es);
    lat = (ec != 0) ? es + 1 : N;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 1; n <= lat + 1; n++) begin
      @(negedge clk);
      start = (poke && n == 2 && lat > 4);
      chk(done == (n == lat), (ec != 0) ? "R9" : "R10", int'(done), int'(n == lat));
      if (n >= lat) begin
        chk(pass == (ec == 0), tag(ec), int'(pass), int'(ec == 0));
        chk(int'(fail_code) == ec, tag(ec), int'(fail_code), ec);
        chk(int'(fail_slot) == es, "R9", int'(fail_slot), es);
      end
    end
    start = 1'b0;
  endtask

  task automatic base();
    prog[0]  = S(1, P(0), P(1), R(0));
    prog[1]  = S(3, NONE, R(0), R(1));
    prog[2]  = {1'b0, 3'd0, R(9), R(9), R(9)};
    prog[3]  = S(2, R(0), P(2), R(2));
    prog[4]  = S(4, P(2), P(3), P(2));
    prog[5]  = S(5, R(1), R(2), R(3));
    prog[6]  = S(6, NONE, R(3), P(0));
    prog[7]  = S(7, R(3), P(0), R(4));
    prog[8]  = S(1, R(4), R(0), R(5));
    prog[9]  = S(2, R(5), R(1), R(6));
    prog[10] = S(4, R(6), P(1), R(7));
    prog[11] = S(3, NONE, R(7), R(8));
    prog[12] = S(5, R(8), R(2), R(9));
    prog[13] = S(6, NONE, R(9), P(3));
  endtask

  task automatic random_prog();
    bit w[10]; int nw;
    foreach (w[k]) w[k] = 1'b0;
    nw = 0;
    for (int i = 0; i < N; i++) begin
      int g; logic [5:0] a, b, d; int pick;
      if ($urandom_range(0, 5) == 0) begin
        prog[i] = {1'b0, 21'($urandom)};
        continue;
      end
      g = $urandom_range(1, 7);
      b = P($urandom_range(0, 3));
      if (nw > 0 && $urandom_range(0, 1) == 1) begin
        pick = $urandom_range(0, 9);
        while (!w[pick]) pick = (pick + 1) % 10;
        b = R(pick);
      end
      a = NONE;
      if (g != 3 && g != 6) begin
        a = P((int'(b[3:0]) + 1) % 4);
        if (b[4]) a = P($urandom_range(0, 3));
      end
      d = P($urandom_range(0, 3));
      if (nw < 10 && $urandom_range(0, 2) != 0) begin
        pick = $urandom_range(0, 9);
        while (w[pick]) pick = (pick + 1) % 10;
        d = R(pick); w[pick] = 1'b1; nw++;
      end
      prog[i] = S(g, a, b, d);
    end
    if ($urandom_range(0, 2) != 0) begin
      int k, f;
      k = $urandom_range(0, N - 1);
      f = $urandom_range(0, 3);
      case (f)
        0: prog[k][20:18] = 3'($urandom_range(0, 7));
        1: prog[k][17:12] = R($urandom_range(0, 9)) & {$urandom_range(0, 1) == 1, 5'h1f};
        2: prog[k][11:6]  = R($urandom_range(0, 9));
        default: prog[k][5:0] = R($urandom_range(0, 9));
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (prog[k]) prog[k] = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && pass == 1'b0, "R10", int'(done | pass), 0);
    chk(fail_code == 3'd0 && fail_slot == 4'd0, "R10", int'(fail_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(1'b0);                                            // R2 empty program
    base(); run(1'b0);                                    // R1, R2, R6 port reuse
    base(); run(1'b1);                                    // R10 start ignored
    base(); prog[3] = {1'b1, 3'd0, P(0), P(0), NONE}; run(1'b0);   // R3 over R4
    base(); prog[1] = S(3, P(0), R(0), R(1)); run(1'b0);  // R4 unary
    base(); prog[5] = S(5, R(1), R(2), NONE); run(1'b0);  // R4 binary
    base(); prog[4] = S(4, P(2), P(2), P(1)); run(1'b0);  // R5 ports
    base(); prog[8] = S(1, R(4), R(4), R(5)); run(1'b0);  // R5 registers
    base(); prog[9] = S(2, R(5), R(1), R(5)); run(1'b0);  // R6 over R8
    base(); prog[7] = S(7, R(7), P(0), R(4)); run(1'b0);  // R7 operand A
    base(); prog[10] = S(4, P(1), R(9), R(7)); run(1'b0); // R7 operand B
    base(); prog[13] = S(6, NONE, R(9), R(0)); run(1'b0); // R8 late slot
    base(); prog[6][20:18] = 3'd0; prog[11] = S(3, P(0), P(0), NONE); run(1'b0); // R9 first
    base(); prog[0] = S(1, P(1), P(1), NONE); run(1'b0);  // R9 priority R4 before R5

    for (int t = 0; t < 400; t++) begin
      random_prog();
      run(t % 7 == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule